// File: doc/BRIEF.md
# Three-Phase Head Stepper Sequencer

This block turns step commands from a disk controller into the three phase-enable outputs of a head-positioning stepper motor. Exactly one of the phases A, B and C is on at any time. Each accepted step command moves the active phase one place. The order depends on the direction. Moving toward the spindle (inward) runs A, B, C, A. Moving away from it (outward) runs A, C, B, A. A step can come from the single step line, which takes its direction from a direction line, or from two dedicated lines, one that always steps inward and one that always steps outward.

The leading edge of a step command starts a short one-shot. The phase register changes only when that one-shot expires, and it uses the direction as it stands at that moment. A second, longer retriggerable timer keeps the motor at full holding power while steps keep arriving. It drops power once no step has been accepted for its whole period. A track-zero status output reports the track-zero sensor, but only when phase A is active and the unit is selected. Every control input passes through a two-flop synchroniser before the block uses it.

Top module: `seek_phase_driver`

## Requirements
- R1: While reset is held and on the first cycle after it, phase A alone is active (`ph_a`=1, `ph_b`=0, `ph_c`=0) and `full_power` is 0.
- R2: Exactly one of `ph_a`, `ph_b`, `ph_c` is 1 in every cycle.
- R3: A step on `step` with `dir_out`=0 (inward) moves the active phase A→B, B→C, C→A.
- R4: A step on `step` with `dir_out`=1 (outward) moves the active phase A→C, C→B, B→A.
- R5: A rising edge on `step_in` always steps inward and one on `step_out` always steps outward, whatever `dir_out` is. If several step lines rise in the same cycle, `step_in` wins over `step_out`, and `step_out` wins over `step`.
- R6: The phase outputs do not change until `PULSE_CYCLES` cycles after the step edge has been accepted. The direction for a `step`-line command is the `dir_out` value seen at that update, not the value seen at the edge.
- R7: A step edge that arrives while the one-shot of an earlier accepted step is still running has no effect.
- R8: While `unit_sel` is 0, step edges on all three lines are ignored: neither the phase nor `full_power` changes.
- R9: `full_power` rises when a step is accepted. It stays 1 until `HOLD_CYCLES` cycles have passed without another accepted step, then falls to 0. Steps spaced closer than `HOLD_CYCLES` keep it at 1 continuously.
- R10: `track00` is 1 exactly when `trk0_sense` is 1, phase A is active and `unit_sel` is 1, all three taken after synchronisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Step command; the rising edge counts |
| dir_out | input | 1 | Direction for `step`: 0 inward, 1 outward |
| step_in | input | 1 | Dedicated inward step line; the rising edge counts |
| step_out | input | 1 | Dedicated outward step line; the rising edge counts |
| unit_sel | input | 1 | Unit selected; step commands are ignored when low |
| trk0_sense | input | 1 | Track-zero sensor, active high |
| ph_a | output | 1 | Phase A enable |
| ph_b | output | 1 | Phase B enable |
| ph_c | output | 1 | Phase C enable |
| full_power | output | 1 | Full holding power enable |
| track00 | output | 1 | Track-zero status |

## Verification
A wrong phase state shows at once on the three phase outputs, since they are the state register itself. A wrong transition therefore appears about `PULSE_CYCLES` plus three cycles after the step edge, and a lost one-hot encoding appears in the same cycle. A one-shot that is faulty or releases early moves the phase before the window in R6 has passed, or lets a second, overlapping edge move it again. A faulty hold timer shows in `full_power` either right after the accepting edge or around the `HOLD_CYCLES` boundary. A bad track-zero gating shows in `track00` within three cycles of the sensor, select or phase input changing.

// File: rtl/seek_pkg.sv
package seek_pkg;

    // One-hot phase state: bit 0 = A, bit 1 = B, bit 2 = C
    typedef enum logic [2:0] {
        PH_A = 3'b001,
        PH_B = 3'b010,
        PH_C = 3'b100
    } phase_t;

    // Which line issued the pending step
    typedef enum logic [1:0] {
        SRC_LINE = 2'd0,
        SRC_IN   = 2'd1,
        SRC_OUT  = 2'd2
    } step_src_t;

    // Synchronised control bundle
    typedef struct packed {
        logic step;
        logic step_in;
        logic step_out;
        logic dir_out;
        logic unit_sel;
        logic trk0;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // Steering: next phase from current phase and direction
    function automatic phase_t phase_after(phase_t cur, logic outward);
        phase_t nxt;
        case (cur)
            PH_A:    nxt = outward ? PH_C : PH_B;
            PH_B:    nxt = outward ? PH_A : PH_C;
            PH_C:    nxt = outward ? PH_B : PH_A;
            default: nxt = PH_A;
        endcase
        return nxt;
    endfunction

    // Resolve direction of the pending step at update time
    function automatic logic resolve_outward(step_src_t src, logic dir_line);
        logic o;
        case (src)
            SRC_IN:  o = 1'b0;
            SRC_OUT: o = 1'b1;
            default: o = dir_line;
        endcase
        return o;
    endfunction

    // Source selection with fixed priority: in, out, plain step
    function automatic step_src_t pick_source(logic r_step, logic r_in, logic r_out);
        step_src_t s;
        if (r_in)       s = SRC_IN;
        else if (r_out) s = SRC_OUT;
        else            s = SRC_LINE;
        if (!r_step && !r_in && !r_out) s = SRC_LINE;
        return s;
    endfunction

endpackage

// File: rtl/seek_sync.sv
module seek_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/seek_step_front.sv
module seek_step_front
    import seek_pkg::*;
#(
    parameter int PULSE_CYCLES = 600
) (
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl,
    output logic accept,
    output logic busy,
    output logic upd,
    output logic upd_out
);
    localparam int CW = $clog2(PULSE_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES - 1);

    logic [2:0]  lines, prev, rise;
    logic [CW-1:0] cnt;
    step_src_t   src_q;
    logic        any_rise;

    assign lines    = {ctl.step, ctl.step_in, ctl.step_out};
    assign rise     = lines & ~prev;
    assign any_rise = |rise;
    assign accept   = any_rise && ctl.unit_sel && !busy;
    assign upd      = busy && (cnt == '0);
    assign upd_out  = resolve_outward(src_q, ctl.dir_out);

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= lines;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt   <= '0;
            src_q <= SRC_LINE;
        end else if (accept) begin
            busy  <= 1'b1;
            cnt   <= LOAD;
            src_q <= pick_source(rise[2], rise[1], rise[0]);
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    AST_UNSEL_NO_START: assert property (@(posedge clk) disable iff (rst)
        !ctl.unit_sel |=> !$rose(busy)) else $error("unselected start"); // R8
    AST_START_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        !any_rise |=> !$rose(busy)) else $error("start without edge"); // R7
endmodule

// File: rtl/seek_phase_reg.sv
module seek_phase_reg
    import seek_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   upd,
    input  logic   upd_out,
    output phase_t phase
);
    always_ff @(posedge clk) begin
        if (rst)      phase <= PH_A;
        else if (upd) phase <= phase_after(phase, upd_out);
    end

    AST_PHASE_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
        $countones(phase) == 1) else $error("phase not one-hot"); // R2
    AST_MOVE_ONLY_ON_UPD: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(phase)) else $error("phase moved without update"); // R6
endmodule

// File: rtl/seek_hold_timer.sv
module seek_hold_timer #(
    parameter int HOLD_CYCLES = 3_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    output logic full_power
);
    localparam int HW = $clog2(HOLD_CYCLES + 1);

    logic [HW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)               remain <= '0;
        else if (kick)         remain <= HW'(HOLD_CYCLES);
        else if (remain != '0) remain <= remain - 1'b1;
    end

    assign full_power = (remain != '0);

    AST_KICK_POWERS: assert property (@(posedge clk) disable iff (rst)
        kick |=> full_power) else $error("kick without power"); // R9
endmodule

// File: rtl/seek_phase_driver.sv
module seek_phase_driver
    import seek_pkg::*;
#(
    parameter int PULSE_CYCLES = 600,
    parameter int HOLD_CYCLES  = 3_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic dir_out,
    input  logic step_in,
    input  logic step_out,
    input  logic unit_sel,
    input  logic trk0_sense,
    output logic ph_a,
    output logic ph_b,
    output logic ph_c,
    output logic full_power,
    output logic track00
);
    ctl_t   raw, syn;
    logic   accept, busy, upd, upd_out;
    phase_t phase;

    assign raw = '{step: step, step_in: step_in, step_out: step_out,
                   dir_out: dir_out, unit_sel: unit_sel, trk0: trk0_sense};

    seek_sync #(.WIDTH(CTL_W), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d(raw), .q(syn)
    );

    seek_step_front #(.PULSE_CYCLES(PULSE_CYCLES)) u_front (
        .clk(clk), .rst(rst), .ctl(syn),
        .accept(accept), .busy(busy), .upd(upd), .upd_out(upd_out)
    );

    seek_phase_reg u_phase (
        .clk(clk), .rst(rst), .upd(upd), .upd_out(upd_out), .phase(phase)
    );

    seek_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk(clk), .rst(rst), .kick(accept), .full_power(full_power)
    );

    assign ph_a    = phase[0];
    assign ph_b    = phase[1];
    assign ph_c    = phase[2];
    assign track00 = syn.trk0 && (phase == PH_A) && syn.unit_sel;

    AST_TRACK_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        track00 |-> (ph_a && !ph_b && !ph_c)) else $error("track00 off phase A"); // R10
    AST_UPD_UNDER_POWER: assert property (@(posedge clk) disable iff (rst)
        upd |-> full_power) else $error("update with power reduced"); // R9
    AST_BUSY_HOLDS_POWER: assert property (@(posedge clk) disable iff (rst)
        busy |-> full_power) else $error("one-shot running without power"); // R7
    AST_RESET_PHASE_A: assert property (@(posedge clk)
        $past(rst) |-> (ph_a && !full_power)) else $error("reset state"); // R1
endmodule

// File: tb/test_seek_phase_driver.sv
module test_seek_phase_driver;
    localparam int P = 8;
    localparam int H = 120;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic step = 0, dir_out = 0, step_in = 0, step_out = 0, unit_sel = 1, trk0_sense = 0;
    logic ph_a, ph_b, ph_c, full_power, track00;

    int checks = 0;
    int errors = 0;
    int model = 0; // 0=A 1=B 2=C
    bit done = 0;

    always #2.5 clk = ~clk;

    seek_phase_driver #(.PULSE_CYCLES(P), .HOLD_CYCLES(H)) i_seek_phase_driver (
        .clk(clk), .rst(rst), .step(step), .dir_out(dir_out), .step_in(step_in),
        .step_out(step_out), .unit_sel(unit_sel), .trk0_sense(trk0_sense),
        .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c), .full_power(full_power), .track00(track00)
    );

    function automatic int nxt(int cur, bit outward);
        if (outward) return (cur + 2) % 3;
        return (cur + 1) % 3;
    endfunction

    function automatic logic [2:0] onehot(int p);
        return 3'b001 << p;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // kind: 0 = step line, 1 = step_in, 2 = step_out
    task automatic pulse(int kind);
        @(negedge clk);
        case (kind)
            0: step = 1;
            1: step_in = 1;
            default: step_out = 1;
        endcase
        cyc(2);
        step = 0; step_in = 0; step_out = 0;
    endtask

    task automatic check_phase(string req);
        chk(req, {29'd0, ph_c, ph_b, ph_a}, {29'd0, onehot(model)});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        // R1 reset state
        cyc(3);
        check_phase("R1");
        chk("R1 power", full_power, 0);
        rst = 0;
        @(negedge clk);
        check_phase("R1 after release");
        chk("R1 power after release", full_power, 0);
        cyc(3);

        // R3 inward full cycle
        dir_out = 0;
        for (int i = 0; i < 3; i++) begin
            pulse(0); cyc(P + 6);
            model = nxt(model, 0);
            check_phase("R3");
        end
        // R4 outward full cycle
        dir_out = 1; cyc(3);
        for (int i = 0; i < 3; i++) begin
            pulse(0); cyc(P + 6);
            model = nxt(model, 1);
            check_phase("R4");
        end

        // R5 dedicated lines override dir_out
        dir_out = 1; cyc(3);
        pulse(1); cyc(P + 6); model = nxt(model, 0); check_phase("R5 step_in");
        dir_out = 0; cyc(3);
        pulse(2); cyc(P + 6); model = nxt(model, 1); check_phase("R5 step_out");
        // R5 priority: step_in and step_out together -> inward
        @(negedge clk); step_in = 1; step_out = 1; step = 1; dir_out = 1;
        cyc(2); step_in = 0; step_out = 0; step = 0;
        cyc(P + 6); model = nxt(model, 0); check_phase("R5 priority in");
        // step_out with step together -> outward even with dir_out=0
        dir_out = 0; cyc(3);
        @(negedge clk); step_out = 1; step = 1;
        cyc(2); step_out = 0; step = 0;
        cyc(P + 6); model = nxt(model, 1); check_phase("R5 priority out");

        // R6 no change before the one-shot expires; direction sampled late
        dir_out = 0; cyc(3);
        @(negedge clk); step = 1;
        cyc(2); step = 0;
        cyc(2); dir_out = 1;   // flips before expiry
        cyc(P - 4);            // edge count P since step rose: not yet updated
        check_phase("R6 early");
        cyc(10);
        model = nxt(model, 1);
        check_phase("R6 late direction");

        // R7 second edge inside one-shot ignored
        dir_out = 0; cyc(3);
        pulse(0); cyc(1); pulse(0);
        cyc(P + 8);
        model = nxt(model, 0);
        check_phase("R7 single move");

        // R8 unselected steps ignored, power unaffected
        cyc(H + 10);
        chk("R9 power dropped", full_power, 0);
        unit_sel = 0; cyc(3);
        pulse(0); pulse(1); pulse(2);
        cyc(P + 6);
        check_phase("R8 phase");
        chk("R8 power", full_power, 0);
        unit_sel = 1; cyc(3);

        // R9 exact hold window
        pulse(0);           // rises at edge 1; accept at edge 3
        model = nxt(model, dir_out);
        cyc(H - 4);         // edge H-2
        chk("R9 held", full_power, 1);
        cyc(10);            // edge H+8
        chk("R9 dropped", full_power, 0);
        // R9 retrigger: steps every H/2 keep power continuously
        for (int i = 0; i < 5; i++) begin
            pulse(0);
            model = nxt(model, dir_out);
            for (int k = 0; k < H / 2 - 2; k++) begin
                @(negedge clk);
                if (i > 0 || k > 2) chk("R9 continuous", full_power, 1);
            end
        end
        check_phase("R9 phase");

        // R10 track00 gating
        while (model != 0) begin
            pulse(1); cyc(P + 6); model = nxt(model, 0);
        end
        trk0_sense = 1; cyc(4);
        chk("R10 set", track00, 1);
        unit_sel = 0; cyc(4);
        chk("R10 unselected", track00, 0);
        unit_sel = 1; cyc(4);
        pulse(1); cyc(P + 6); model = nxt(model, 0);
        chk("R10 phase B", track00, 0);
        trk0_sense = 0; cyc(4);
        pulse(2); cyc(P + 6); model = nxt(model, 1);
        chk("R10 sensor off", track00, 0);

        // Random mix (R2, R3, R4, R5, R8)
        for (int i = 0; i < 60; i++) begin
            int kind;
            bit d, sel, outward;
            kind = int'($urandom % 3);
            d    = 1'($urandom % 2);
            sel  = ($urandom % 5) != 0;
            dir_out = d; unit_sel = sel;
            cyc(3);
            pulse(kind);
            cyc(P + 6);
            outward = (kind == 1) ? 1'b0 : (kind == 2) ? 1'b1 : d;
            if (sel) model = nxt(model, outward);
            check_phase("R2 random");
            if (sel) chk("R9 random", full_power, 1);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule